// File: doc/BRIEF.md
# Serial Register Command Engine for a Temperature Sensor

This block is the serial slave front end of a temperature-sensor register file. A master talks to it over a three-wire link. The wires are a serial clock, an active-low select, and one data line that carries traffic in both directions. On the data line, the block supplies `spi_sdo` and an output enable, and it reads `spi_sdi`. The pad ties the three together. All serial inputs are synchronised into the system clock and oversampled. The serial clock must idle low, and its period must be at least four system clocks. The block drives a new data bit after each falling serial-clock edge and samples incoming bits on each rising edge.

While the select stays low, the line carries 16-bit words in strict alternation. First comes a response word from the block, then a command word from the master, then another response, and so on. Each response returns the register picked by a 2-bit read pointer. The four registers are:
- the live temperature code, which is an input;
- a 9-bit configuration word, held locally;
- a 13-bit low limit, held locally;
- a 13-bit high limit, held locally.

The pointer is sticky. A read command sets it. Only a response that runs to its sixteenth clock returns it to the temperature register, so an aborted read repeats on the next select.

Commands can write the configuration or either limit, redirect the next response, or request shutdown. The block emits one-cycle strobes for each write, for every completed response (the alert logic uses this one to clear), and for shutdown requests. It also holds a shutdown level.

Top module: `tsif_engine`

## Requirements
- R1: After reset, the registers hold these values:
  - configuration = 0x060 (resolution field set to its maximum, all else zero);
  - low limit = 0x04B0;
  - high limit = 0x0500;
  - shutdown level = 0;
  - output enable = 0;
  - read pointer selects temperature.
- R2: Once the select falls, the block drives the word picked by the read pointer. Bit 15 is available before the first rising clock edge, and each later bit follows a falling edge, most significant bit first.
- R3: A temperature response carries the 13-bit code in bits 15:3 and a 1 in bit 2. The output enable is low while bits 1:0 are on the line.
- R4: A response cut short by a rising select leaves the pointer unchanged, and the same register is returned at the next select. A response that completes all 16 clocks resets the pointer to 00 and produces exactly one `read_done` pulse.
- R5: When the select stays low after a response, the next 16 rising edges shift in a command word, MSB first. The output enable stays low during the command. The next response then follows at once.
- R6: A word of the form 1000_0000_000a_a000 is a read command, and the next response returns register aa. The pointer codes are:
  - 00 temperature;
  - 01 configuration, read back as {0000, cfg[8:0], 010};
  - 10 low limit, read back as {value, 100};
  - 11 high limit, read back as {value, 110}.
  
  A word that sets any other bit is not a read.
- R7: A command with bits 2:0 = 010 loads bits 11:3 into the configuration register and pulses `cfg_wr_stb`. The configuration output changes only with that strobe.
- R8: Bits 2:0 = 100 load bits 15:3 into the low limit, and bits 2:0 = 110 load them into the high limit. Each write pulses its own strobe, and each limit changes only with its strobe.
- R9: A write leaves the pointer alone, so the next response returns temperature.
- R10: A command whose bits 7:0 are all ones sets `shdn_mode` and pulses `shdn_stb`. Any later command whose bits 7:0 are not all ones clears `shdn_mode`, including a command that matches no other pattern. No two write or shutdown strobes are ever high together.
- R11: The output enable falls as soon as the select rises, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from master, idle low |
| spi_cs_n | input | 1 | Active-low select |
| spi_sdi | input | 1 | Data line as seen by the block |
| temp_code | input | 13 | Latest temperature conversion, two's complement |
| spi_sdo | output | 1 | Data the block drives onto the line |
| spi_sdo_oe | output | 1 | Drive enable for the data line |
| cfg_bits | output | 9 | Configuration register |
| lim_low | output | 13 | Low limit register |
| lim_high | output | 13 | High limit register |
| cfg_wr_stb | output | 1 | One-cycle pulse on a configuration write |
| low_wr_stb | output | 1 | One-cycle pulse on a low-limit write |
| high_wr_stb | output | 1 | One-cycle pulse on a high-limit write |
| read_done | output | 1 | One-cycle pulse when a response completes |
| shdn_stb | output | 1 | One-cycle pulse on a shutdown command |
| shdn_mode | output | 1 | Shutdown level |

## Verification
The hardest state to reach is a pointer left non-zero across a select boundary. This state exists only when a read command has been accepted and the response that follows it is then aborted. The stimulus reaches it as follows:
1. Keep the select low through a full response.
2. Shift in a high-limit read command.
3. Clock only five bits of the response, then raise the select mid-word, which also checks that the output enable falls without a clock edge.
4. Reopen the select to see the limit returned again.
5. Open the select once more to see the pointer fall back to temperature.

A table of single-session transactions covers the command decoding. Each transaction returns a response, takes a command, and returns a second response. The table includes near-miss words that must be ignored.

// File: rtl/tsif_pkg.sv
package tsif_pkg;
  localparam int WORD_W   = 16;
  localparam int TEMP_W   = 13;
  localparam int CFG_W    = 9;
  localparam int PTR_W    = 2;
  localparam int TAG_W    = 3;
  localparam int HIZ_BITS = 2;
  localparam int CFG_PAD  = WORD_W - CFG_W - TAG_W;

  typedef enum logic [1:0] {PH_IDLE, PH_RESP, PH_CMD} phase_e;

  localparam logic [PTR_W-1:0] SEL_TEMP = 2'b00;
  localparam logic [PTR_W-1:0] SEL_CFG  = 2'b01;
  localparam logic [PTR_W-1:0] SEL_LOW  = 2'b10;
  localparam logic [PTR_W-1:0] SEL_HIGH = 2'b11;

  localparam logic [TAG_W-1:0] TAG_CFG  = 3'b010;
  localparam logic [TAG_W-1:0] TAG_LOW  = 3'b100;
  localparam logic [TAG_W-1:0] TAG_HIGH = 3'b110;

  localparam logic [WORD_W-1:0] RD_MASK = 16'h7FE7;

  localparam logic [CFG_W-1:0]  CFG_RST  = 9'h060;
  localparam logic [TEMP_W-1:0] LOW_RST  = 13'h04B0;
  localparam logic [TEMP_W-1:0] HIGH_RST = 13'h0500;
endpackage

// File: rtl/tsif_sync.sv
module tsif_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
      else        chain_q <= {chain_q[STAGES-2:0], d[i]};
    end
    assign q[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/tsif_frame.sv
module tsif_frame
  import tsif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  input  logic [WORD_W-1:0] load_word,
  input  logic              load_hiz,
  output logic              resp_done,
  output logic              cmd_fire,
  output logic [WORD_W-1:0] cmd_word,
  output logic              in_resp,
  output logic              sdo_bit,
  output logic              hiz_now
);
  localparam int               CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] HIZ_N = CNT_W'(HIZ_BITS);

  logic              sck_q, cs_q;
  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] tx_q, tx_d;
  logic              hiz_q, hiz_d;
  logic [WORD_W-2:0] rx_q, rx_d;
  logic              sck_rise, sck_fall, cs_fall, cs_rise;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_fall  = cs_q & ~cs_n_s;
  assign cs_rise  = ~cs_q & cs_n_s;
  assign cmd_word = {rx_q, sdi_s};

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    idx_d     = idx_q;
    tx_d      = tx_q;
    hiz_d     = hiz_q;
    rx_d      = rx_q;
    resp_done = 1'b0;
    cmd_fire  = 1'b0;
    if (cs_rise) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (cs_fall) begin
      phase_d = PH_RESP;
      cnt_d   = '0;
      idx_d   = LAST;
      tx_d    = load_word;
      hiz_d   = load_hiz;
    end else begin
      case (phase_q)
        PH_RESP: begin
          if (sck_rise) begin
            if (cnt_q == LAST) begin
              phase_d   = PH_CMD;
              cnt_d     = '0;
              resp_done = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else if (sck_fall && (cnt_q != '0) && (idx_q != '0)) begin
            idx_d = idx_q - 1'b1;
          end
        end
        PH_CMD: begin
          if (sck_rise) begin
            rx_d = cmd_word[WORD_W-2:0];
            if (cnt_q == LAST) begin
              cmd_fire = 1'b1;
              phase_d  = PH_RESP;
              cnt_d    = '0;
              idx_d    = LAST;
              tx_d     = load_word;
              hiz_d    = load_hiz;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      tx_q    <= '0;
      hiz_q   <= 1'b0;
      rx_q    <= '0;
    end else begin
      sck_q   <= sck_s;
      cs_q    <= cs_n_s;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      tx_q    <= tx_d;
      hiz_q   <= hiz_d;
      rx_q    <= rx_d;
    end
  end

  assign in_resp = (phase_q == PH_RESP);
  assign sdo_bit = tx_q[idx_q];
  assign hiz_now = hiz_q & (idx_q < HIZ_N);
endmodule

// File: rtl/tsif_regs.sv
module tsif_regs
  import tsif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              resp_done,
  input  logic [TEMP_W-1:0] temp_code,
  output logic [WORD_W-1:0] load_word,
  output logic              load_hiz,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [TEMP_W-1:0] low_q,
  output logic [TEMP_W-1:0] high_q,
  output logic              cfg_stb,
  output logic              low_stb,
  output logic              high_stb,
  output logic              rd_done,
  output logic              shdn_stb,
  output logic              shdn_q
);
  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_eff;
  logic             is_rd, is_sd, cfg_en, low_en, high_en, shdn_d;
  logic [TAG_W-1:0] tag;

  assign tag   = cmd_word[TAG_W-1:0];
  assign is_rd = cmd_word[WORD_W-1] && ((cmd_word & RD_MASK) == '0);
  assign is_sd = &cmd_word[7:0];

  always_comb begin
    cfg_en  = cmd_fire && (tag == TAG_CFG);
    low_en  = cmd_fire && (tag == TAG_LOW);
    high_en = cmd_fire && (tag == TAG_HIGH);
    shdn_d  = cmd_fire ? is_sd : shdn_q;
    ptr_eff = (cmd_fire && is_rd) ? cmd_word[4:3] : ptr_q;
    ptr_d   = ptr_q;
    if (cmd_fire && is_rd) ptr_d = cmd_word[4:3];
    else if (resp_done)    ptr_d = SEL_TEMP;
  end

  always_comb begin
    load_hiz = 1'b0;
    case (ptr_eff)
      SEL_CFG:  load_word = {{CFG_PAD{1'b0}}, cfg_q, TAG_CFG};
      SEL_LOW:  load_word = {low_q, TAG_LOW};
      SEL_HIGH: load_word = {high_q, TAG_HIGH};
      default: begin
        load_word = {temp_code, 1'b1, {HIZ_BITS{1'b0}}};
        load_hiz  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= SEL_TEMP;
      cfg_q    <= CFG_RST;
      low_q    <= LOW_RST;
      high_q   <= HIGH_RST;
      shdn_q   <= 1'b0;
      cfg_stb  <= 1'b0;
      low_stb  <= 1'b0;
      high_stb <= 1'b0;
      rd_done  <= 1'b0;
      shdn_stb <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      shdn_q   <= shdn_d;
      cfg_stb  <= cfg_en;
      low_stb  <= low_en;
      high_stb <= high_en;
      rd_done  <= resp_done;
      shdn_stb <= cmd_fire && is_sd;
      if (cfg_en)  cfg_q  <= cmd_word[CFG_W+TAG_W-1:TAG_W];
      if (low_en)  low_q  <= cmd_word[WORD_W-1:TAG_W];
      if (high_en) high_q <= cmd_word[WORD_W-1:TAG_W];
    end
  end
endmodule

// File: rtl/tsif_engine.sv
module tsif_engine
  import tsif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_sdi,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              spi_sdo,
  output logic              spi_sdo_oe,
  output logic [CFG_W-1:0]  cfg_bits,
  output logic [TEMP_W-1:0] lim_low,
  output logic [TEMP_W-1:0] lim_high,
  output logic              cfg_wr_stb,
  output logic              low_wr_stb,
  output logic              high_wr_stb,
  output logic              read_done,
  output logic              shdn_stb,
  output logic              shdn_mode
);
  logic              rst_meta, rst_core_n;
  logic [2:0]        pins_s;
  logic              resp_done, cmd_fire, in_resp, sdo_bit, hiz_now, load_hiz;
  logic [WORD_W-1:0] cmd_word, load_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  tsif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({spi_sdi, spi_cs_n, spi_sck}),
    .q     (pins_s)
  );

  tsif_frame u_frame (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sck_s     (pins_s[0]),
    .cs_n_s    (pins_s[1]),
    .sdi_s     (pins_s[2]),
    .load_word (load_word),
    .load_hiz  (load_hiz),
    .resp_done (resp_done),
    .cmd_fire  (cmd_fire),
    .cmd_word  (cmd_word),
    .in_resp   (in_resp),
    .sdo_bit   (sdo_bit),
    .hiz_now   (hiz_now)
  );

  tsif_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cmd_fire  (cmd_fire),
    .cmd_word  (cmd_word),
    .resp_done (resp_done),
    .temp_code (temp_code),
    .load_word (load_word),
    .load_hiz  (load_hiz),
    .cfg_q     (cfg_bits),
    .low_q     (lim_low),
    .high_q    (lim_high),
    .cfg_stb   (cfg_wr_stb),
    .low_stb   (low_wr_stb),
    .high_stb  (high_wr_stb),
    .rd_done   (read_done),
    .shdn_stb  (shdn_stb),
    .shdn_q    (shdn_mode)
  );

  assign spi_sdo    = sdo_bit;
  assign spi_sdo_oe = ~spi_cs_n & in_resp & ~hiz_now;
endmodule

// File: rtl/tsif_engine_chk.sv
module tsif_engine_chk
  import tsif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_W-1:0]  cfg_bits,
  input logic [TEMP_W-1:0] lim_low,
  input logic [TEMP_W-1:0] lim_high,
  input logic              cfg_wr_stb,
  input logic              low_wr_stb,
  input logic              high_wr_stb,
  input logic              read_done,
  input logic              shdn_stb,
  input logic              shdn_mode
);
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_wr_stb, low_wr_stb, high_wr_stb, shdn_stb})); // R10
  AST_CFG_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_bits) |-> cfg_wr_stb); // R7
  AST_LOW_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lim_low) |-> low_wr_stb); // R8
  AST_HIGH_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lim_high) |-> high_wr_stb); // R8
  AST_READ_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |=> !read_done); // R4
  AST_SHDN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_stb |-> shdn_mode); // R10
endmodule

bind tsif_engine tsif_engine_chk u_chk (.*);

// File: tb/tsif_engine_tb.sv
module tsif_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam logic [15:0] TW = 16'h0C84;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        spi_sck, spi_cs_n, spi_sdi;
  logic [12:0] temp_code;
  logic        spi_sdo, spi_sdo_oe;
  logic [8:0]  cfg_bits;
  logic [12:0] lim_low, lim_high;
  logic        cfg_wr_stb, low_wr_stb, high_wr_stb, read_done, shdn_stb, shdn_mode;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0, cfg_cnt = 0, low_cnt = 0, high_cnt = 0, sd_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsif_engine u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_sdi(spi_sdi), .temp_code(temp_code), .spi_sdo(spi_sdo),
    .spi_sdo_oe(spi_sdo_oe), .cfg_bits(cfg_bits), .lim_low(lim_low),
    .lim_high(lim_high), .cfg_wr_stb(cfg_wr_stb), .low_wr_stb(low_wr_stb),
    .high_wr_stb(high_wr_stb), .read_done(read_done), .shdn_stb(shdn_stb),
    .shdn_mode(shdn_mode)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (read_done)   rd_cnt++;
      if (cfg_wr_stb)  cfg_cnt++;
      if (low_wr_stb)  low_cnt++;
      if (high_wr_stb) high_cnt++;
      if (shdn_stb)    sd_cnt++;
    end
  end

  typedef struct packed {
    logic [15:0] exp1;
    logic [15:0] cmd;
    logic [15:0] exp2;
    logic        t2;
    logic        sd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{TW, 16'h8008, 16'h0302, 1'b0, 1'b0},  // R6 R1 config reset readback
    '{TW, 16'h8010, 16'h2584, 1'b0, 1'b0},  // R6 R1 low limit reset
    '{TW, 16'h8018, 16'h2806, 1'b0, 1'b0},  // R6 R1 high limit reset
    '{TW, 16'h8000, TW,       1'b1, 1'b0},  // R6 explicit temp read
    '{TW, 16'h0D2A, TW,       1'b1, 1'b0},  // R7 R9 config write
    '{TW, 16'h8008, 16'h0D2A, 1'b0, 1'b0},  // R7 readback
    '{TW, 16'hF9C4, TW,       1'b1, 1'b0},  // R8 R9 low write
    '{TW, 16'h8010, 16'hF9C4, 1'b0, 1'b0},  // R8 readback
    '{TW, 16'h500E, TW,       1'b1, 1'b0},  // R8 R9 high write
    '{TW, 16'h8018, 16'h500E, 1'b0, 1'b0},  // R8 readback
    '{TW, 16'h8108, TW,       1'b1, 1'b0},  // R6 near-miss read ignored
    '{TW, 16'h00FF, TW,       1'b1, 1'b1},  // R10 shutdown
    '{TW, 16'h0000, TW,       1'b1, 1'b0}   // R10 unknown word wakes
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_xfer(input logic din, output logic dout, output logic doe);
    spi_sdi = din;
    repeat (HALF) @(negedge clk);
    dout = spi_sdo;
    doe  = spi_sdo_oe;
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic word_xfer(input logic [15:0] din, input int nbits,
                           output logic [15:0] dout, output logic [15:0] doe);
    logic b, e;
    dout = '0;
    doe  = '0;
    for (int k = 0; k < nbits; k++) begin
      bit_xfer(din[15-k], b, e);
      dout[15-k] = b & e;
      doe[15-k]  = e;
    end
  endtask

  task automatic cs_open();
    spi_cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_close();
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] d, e;
    int rd0;
    rst_n = 1'b0;
    spi_sck = 1'b0;
    spi_cs_n = 1'b1;
    spi_sdi = 1'b0;
    temp_code = 13'h0190;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk("R1 cfg", 32'(cfg_bits), 32'h060);
    chk("R1 low", 32'(lim_low), 32'h04B0);
    chk("R1 high", 32'(lim_high), 32'h0500);
    chk("R1 shdn", 32'(shdn_mode), 32'h0);
    chk("R1 oe", 32'(spi_sdo_oe), 32'h0);

    // Table walk: response, command, response in one select window
    for (int v = 0; v < NV; v++) begin
      cs_open();
      word_xfer(16'h0000, 16, d, e);
      chk("R2 first word", 32'(d), 32'(VECS[v].exp1));
      chk("R3 temp drive mask", 32'(e), 32'hFFFC);
      word_xfer(VECS[v].cmd, 16, d, e);
      chk("R5 oe during command", 32'(e), 32'h0);
      word_xfer(16'h0000, 16, d, e);
      chk("R5/R6/R9 second word", 32'(d), 32'(VECS[v].exp2));
      chk("R3/R6 second mask", 32'(e), VECS[v].t2 ? 32'hFFFC : 32'hFFFF);
      cs_close();
      chk("R10 shutdown level", 32'(shdn_mode), 32'(VECS[v].sd));
    end

    chk("R7 cfg value", 32'(cfg_bits), 32'h1A5);
    chk("R8 low value", 32'(lim_low), 32'h1F38);
    chk("R8 high value", 32'(lim_high), 32'h0A01);
    chk("R7 cfg strobes", 32'(cfg_cnt), 32'd1);
    chk("R8 low strobes", 32'(low_cnt), 32'd1);
    chk("R8 high strobes", 32'(high_cnt), 32'd1);
    chk("R10 shutdown strobes", 32'(sd_cnt), 32'd1);
    chk("R4 read_done count", 32'(rd_cnt), 32'(2*NV));

    // R4 / R11: aborted response keeps pointer
    rd0 = rd_cnt;
    cs_open();
    word_xfer(16'h0000, 16, d, e);
    word_xfer(16'h8018, 16, d, e);
    word_xfer(16'h0000, 5, d, e);
    chk("R4 partial bits", 32'(d[15:11]), 32'h0A);
    chk("R11 oe before select rise", 32'(spi_sdo_oe), 32'h1);
    spi_cs_n = 1'b1;
    #1;
    chk("R11 oe after select rise", 32'(spi_sdo_oe), 32'h0);
    repeat (8) @(negedge clk);
    chk("R4 partial no pulse", 32'(rd_cnt - rd0), 32'd1);

    cs_open();
    word_xfer(16'h0000, 16, d, e);
    cs_close();
    chk("R4 sticky pointer", 32'(d), 32'h500E);
    chk("R4 full read pulse", 32'(rd_cnt - rd0), 32'd2);

    cs_open();
    word_xfer(16'h0000, 16, d, e);
    cs_close();
    chk("R4 pointer back to temp", 32'(d), 32'(TW));

    // R3 with a negative code
    temp_code = 13'h1F38;
    cs_open();
    word_xfer(16'h0000, 16, d, e);
    cs_close();
    chk("R3 negative temp", 32'(d), 32'hF9C4);
    chk("R3 negative mask", 32'(e), 32'hFFFC);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule